// File: doc/BRIEF.md
# Cold/Warm Reset Cause Classifier

After every reset this block works out whether the system is coming up from a real power cycle (cold) or from a user reset with memory still intact (warm). It makes that call from a three-byte signature record kept in ordinary RAM, which it reads over a simple synchronous memory port. The record holds a restart address and a check byte keyed by XOR. A valid record means a warm start, and the stored address is presented as the restart target. An invalid record means a cold start. In that case the block writes a fresh record, holding the configured warm-start address, and presents that address.

No dedicated latch tells cold from warm. Instead, the power-on indication is debounced and, while it is asserted, the block forces a clearing write of 0x00 into the check byte on every high bus-clock phase. A stale record therefore cannot survive a power cycle, while a user reset leaves the record untouched. The classification starts when the last active reset source is released. A reset that arrives in the middle of a sequence aborts it and the sequence runs again after release. The check byte is always written last, so an aborted rewrite never leaves a valid-looking record.

Top module: `boot_cause_top`

## Requirements
- R1: The record sits at RECORD_BASE (low address byte), RECORD_BASE+1 (high address byte) and RECORD_BASE+2 (check byte). When the check byte equals the stored low byte XOR 0xA5, the reset is classed warm, isWarm is set and restartAddr equals {high byte, low byte}.
- R2: When the check byte does not match, the reset is classed cold. The block writes WARM_ADDR[7:0] to RECORD_BASE, then WARM_ADDR[15:8] to RECORD_BASE+1, then WARM_ADDR[7:0] XOR 0xA5 to RECORD_BASE+2. It then sets isCold with restartAddr equal to WARM_ADDR.
- R3: While the debounced power-on indication is active and phaseHigh is 1, the memory port drives memReq=1, memWe=1, memAddr=RECORD_BASE+2 and memWdata=0x00.
- R4: A user reset (userRstN low) with power-on inactive performs no clearing write, so a valid record survives it.
- R5: A change on porRaw takes effect only after it has held its new level for DEB_LEN consecutive clocks. A shorter pulse has no effect on the flags or on the record.
- R6: While any reset is active, done, isCold and isWarm are 0. After a classification, done is high for exactly one cycle. At that point exactly one of isCold and isWarm is 1, and that flag and restartAddr hold their values until the next reset.
- R7: A reset that arrives mid-sequence aborts it. No further record bytes are written, no flag is set, and the check byte is not yet rewritten. After release the sequence runs again from the start.
- R8: A classification starts on the release of either reset source, the user reset or the debounced power-on indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| porRaw | input | 1 | Raw power-on indication, active high |
| userRstN | input | 1 | User reset, active low |
| phaseHigh | input | 1 | High phase of the bus clock |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Write enable for the access |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid the cycle after a read request |
| done | output | 1 | One-cycle pulse when the classification is complete |
| isCold | output | 1 | Reset classed as power-on |
| isWarm | output | 1 | Reset classed as user reset with intact record |
| restartAddr | output | ADDR_W | Restart target address |

## Verification
The bench builds the block with RECORD_BASE=0x0010, WARM_ADDR=0xC123 and DEB_LEN=4. With a short debounce window, both an accepted power cycle and a rejected three-cycle glitch fit in a few cycles. The offset base shows that the record bytes and the clearing write follow the parameter rather than address zero. Because the stored address 0x5634 differs from the configured one, a warm restart can be told apart from a cold rewrite purely by restartAddr and by the RAM contents.

// File: rtl/boot_cause_pkg.sv
package boot_cause_pkg;

  localparam logic [7:0] CHECK_KEY = 8'hA5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_READ_LO,
    ST_READ_HI,
    ST_READ_CHK,
    ST_DECIDE,
    ST_WRITE_LO,
    ST_WRITE_HI,
    ST_WRITE_CHK,
    ST_DONE
  } seqState_t;

  // Record byte selector: 0 = low, 1 = high, 2 = check
  typedef struct packed {
    logic       memReq;
    logic       memWe;
    logic [1:0] sel;
    logic       capLo;
    logic       capHi;
    logic       latchWarm;
    logic       latchCold;
  } ctrlStrb_t;

endpackage

// File: rtl/boot_cause_deb.sv
module boot_cause_deb #(
  parameter int DEB_LEN = 16
) (
  input  logic clk,
  input  logic porRaw,
  output logic porStable
);
  localparam int CW = $clog2(DEB_LEN + 1);

  logic [CW-1:0] cnt;
  logic          seen;

  always_ff @(posedge clk) begin
    seen <= 1'b1;
    if (porRaw == porStable) begin
      cnt <= '0;
    end else if (cnt == CW'(DEB_LEN - 1)) begin
      porStable <= porRaw;
      cnt       <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: an accepted change always follows the raw level
  p_deb_follow_r5: assert property (@(posedge clk)
    (seen && porStable != $past(porStable)) |-> porStable == $past(porRaw));

endmodule

// File: rtl/boot_cause_ctrl.sv
module boot_cause_ctrl
  import boot_cause_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      chkOk,
  output ctrlStrb_t strb
);
  seqState_t state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    strb = '0;
    nxt  = state;
    unique case (state)
      ST_IDLE:     nxt = ST_READ_LO;
      ST_READ_LO:  begin strb.memReq = 1'b1; strb.sel = 2'd0; nxt = ST_READ_HI; end
      ST_READ_HI:  begin strb.memReq = 1'b1; strb.sel = 2'd1; strb.capLo = 1'b1; nxt = ST_READ_CHK; end
      ST_READ_CHK: begin strb.memReq = 1'b1; strb.sel = 2'd2; strb.capHi = 1'b1; nxt = ST_DECIDE; end
      ST_DECIDE: begin
        if (chkOk) begin strb.latchWarm = 1'b1; nxt = ST_DONE; end
        else       nxt = ST_WRITE_LO;
      end
      ST_WRITE_LO:  begin strb.memReq = 1'b1; strb.memWe = 1'b1; strb.sel = 2'd0; nxt = ST_WRITE_HI; end
      ST_WRITE_HI:  begin strb.memReq = 1'b1; strb.memWe = 1'b1; strb.sel = 2'd1; nxt = ST_WRITE_CHK; end
      ST_WRITE_CHK: begin
        strb.memReq = 1'b1; strb.memWe = 1'b1; strb.sel = 2'd2;
        strb.latchCold = 1'b1; nxt = ST_DONE;
      end
      ST_DONE: nxt = ST_DONE;
      default: nxt = ST_IDLE;
    endcase
  end

  // R2: the check byte is only written straight after the high byte
  p_chk_last_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE_CHK) |-> $past(state) == ST_WRITE_HI);

endmodule

// File: rtl/boot_cause_dp.sv
module boot_cause_dp
  import boot_cause_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] RECORD_BASE = '0,
  parameter logic [ADDR_W-1:0] WARM_ADDR   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              porActive,
  input  logic              phaseHigh,
  input  ctrlStrb_t         strb,
  input  logic [7:0]        memRdata,
  output logic              chkOk,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              done,
  output logic              isCold,
  output logic              isWarm,
  output logic [ADDR_W-1:0] restartAddr
);
  localparam logic [ADDR_W-1:0] CLR_ADDR = RECORD_BASE + ADDR_W'(2);
  localparam logic [7:0]        WARM_LO  = WARM_ADDR[7:0];
  localparam logic [7:0]        WARM_HI  = WARM_ADDR[15:8];

  logic [7:0] loReg, hiReg, wrByte;

  assign chkOk = (memRdata == (loReg ^ CHECK_KEY));

  always_comb begin
    unique case (strb.sel)
      2'd0:    wrByte = WARM_LO;
      2'd1:    wrByte = WARM_HI;
      default: wrByte = WARM_LO ^ CHECK_KEY;
    endcase
  end

  always_comb begin
    if (porActive && phaseHigh) begin
      memReq   = 1'b1;
      memWe    = 1'b1;
      memAddr  = CLR_ADDR;
      memWdata = 8'h00;
    end else begin
      memReq   = strb.memReq;
      memWe    = strb.memWe;
      memAddr  = RECORD_BASE + ADDR_W'(strb.sel);
      memWdata = wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.capLo) loReg <= memRdata;
    if (strb.capHi) hiReg <= memRdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      isCold      <= 1'b0;
      isWarm      <= 1'b0;
      restartAddr <= '0;
    end else begin
      done <= strb.latchWarm | strb.latchCold;
      if (strb.latchWarm) begin
        isWarm      <= 1'b1;
        restartAddr <= ADDR_W'({hiReg, loReg});
      end
      if (strb.latchCold) begin
        isCold      <= 1'b1;
        restartAddr <= WARM_ADDR;
      end
    end
  end

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/boot_cause_top.sv
module boot_cause_top
  import boot_cause_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] RECORD_BASE = 16'h0000,
  parameter logic [ADDR_W-1:0] WARM_ADDR   = 16'hC123,
  parameter int                DEB_LEN     = 16
) (
  input  logic              clk,
  input  logic              porRaw,
  input  logic              userRstN,
  input  logic              phaseHigh,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              done,
  output logic              isCold,
  output logic              isWarm,
  output logic [ADDR_W-1:0] restartAddr
);
  localparam logic [ADDR_W-1:0] CHK_ADDR = RECORD_BASE + ADDR_W'(2);

  logic      porStable, rst, chkOk;
  ctrlStrb_t strb;

  assign rst = porStable | ~userRstN;

  boot_cause_deb #(.DEB_LEN(DEB_LEN)) u_deb (
    .clk(clk), .porRaw(porRaw), .porStable(porStable)
  );

  boot_cause_ctrl u_ctrl (
    .clk(clk), .rst(rst), .chkOk(chkOk), .strb(strb)
  );

  boot_cause_dp #(
    .ADDR_W(ADDR_W), .RECORD_BASE(RECORD_BASE), .WARM_ADDR(WARM_ADDR)
  ) u_dp (
    .clk(clk), .rst(rst), .porActive(porStable), .phaseHigh(phaseHigh),
    .strb(strb), .memRdata(memRdata), .chkOk(chkOk),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .done(done), .isCold(isCold), .isWarm(isWarm), .restartAddr(restartAddr)
  );

  // R3: forced clearing write while power-on is active on the high phase
  p_por_clear_r3: assert property (@(posedge clk)
    (porStable && phaseHigh) |-> (memWe && memReq && memAddr == CHK_ADDR && memWdata == 8'h00));

  // R4: with power-on inactive no zero is ever written to the check byte
  p_user_no_clear_r4: assert property (@(posedge clk) disable iff (porStable)
    !(memWe && memAddr == CHK_ADDR && memWdata == 8'h00));

  // R6: at done exactly one cause flag is set
  p_one_cause_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot({isCold, isWarm}));

  // R6: cause and restart address hold until the next reset
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (isCold || isWarm) |=> ($stable({isCold, isWarm}) && $stable(restartAddr)));

  // R6: the two flags are never both set
  p_excl_r6: assert property (@(posedge clk) $onehot0({isCold, isWarm}));

endmodule

// File: tb/sim_boot_cause_top.sv
module sim_boot_cause_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h0010;
  localparam logic [15:0] WARM = 16'hC123;
  localparam int          DEB  = 4;
  localparam logic [7:0]  KEY  = 8'hA5;

  logic        clk = 1'b0;
  logic        porRaw, userRstN, phaseHigh;
  logic        memReq, memWe, done, isCold, isWarm;
  logic [15:0] memAddr, restartAddr;
  logic [7:0]  memWdata, memRdata;

  logic [7:0]  ram [256];
  logic        pokeEn;
  logic [7:0]  pokeAddr, pokeData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_cause_top #(
    .ADDR_W(16), .RECORD_BASE(BASE), .WARM_ADDR(WARM), .DEB_LEN(DEB)
  ) u0 (
    .clk(clk), .porRaw(porRaw), .userRstN(userRstN), .phaseHigh(phaseHigh),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .done(done), .isCold(isCold), .isWarm(isWarm),
    .restartAddr(restartAddr)
  );

  always @(posedge clk) begin
    if (pokeEn) ram[pokeAddr] <= pokeData;
    else if (memReq && memWe) ram[memAddr[7:0]] <= memWdata;
    else if (memReq) memRdata <= ram[memAddr[7:0]];
  end

  initial begin
    phaseHigh = 1'b0;
    forever begin
      @(negedge clk);
      phaseHigh = ~phaseHigh;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = a; pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic setRecord(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] chk);
    poke(BASE[7:0], lo);
    poke(BASE[7:0] + 8'd1, hi);
    poke(BASE[7:0] + 8'd2, chk);
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
    check(done === 1'b1, req, int'(done), 1);
  endtask

  task automatic checkRecord(input string req, input logic [7:0] lo, input logic [7:0] hi);
    check(ram[BASE[7:0]] == lo, req, ram[BASE[7:0]], lo);
    check(ram[BASE[7:0] + 8'd1] == hi, req, ram[BASE[7:0] + 8'd1], hi);
    check(ram[BASE[7:0] + 8'd2] == (lo ^ KEY), req, ram[BASE[7:0] + 8'd2], lo ^ KEY);
  endtask

  task automatic userReset();
    @(negedge clk);
    userRstN = 1'b0;
    cyc(3);
    userRstN = 1'b1;
  endtask

  // Power-on with a stale valid record: clearing write, then cold rewrite
  task automatic testPowerOn();
    setRecord(8'h34, 8'h56, 8'h34 ^ KEY);
    porRaw = 1'b1;
    cyc(12);
    check(!done && !isCold && !isWarm, "R6 reset state", {done, isCold, isWarm}, 0);
    check(ram[BASE[7:0] + 8'd2] == 8'h00, "R3 clearing write", ram[BASE[7:0] + 8'd2], 0);
    porRaw = 1'b0;
    waitDone("R8 power-on release");
    check(isCold && !isWarm, "R2 cold flag", {isCold, isWarm}, 2'b10);
    check(restartAddr == WARM, "R2 cold restart", restartAddr, WARM);
    @(negedge clk);
    checkRecord("R2 record written", WARM[7:0], WARM[15:8]);
    check(!done, "R6 done pulse width", int'(done), 0);
    cyc(3);
    check(isCold && restartAddr == WARM, "R6 hold", restartAddr, WARM);
  endtask

  task automatic testUserWarm();
    setRecord(8'h34, 8'h56, 8'h34 ^ KEY);
    @(negedge clk);
    userRstN = 1'b0;
    cyc(3);
    check(!isCold && !isWarm, "R6 flags clear in user reset", {isCold, isWarm}, 0);
    check(ram[BASE[7:0] + 8'd2] == (8'h34 ^ KEY), "R4 no clear on user reset",
          ram[BASE[7:0] + 8'd2], 8'h34 ^ KEY);
    userRstN = 1'b1;
    waitDone("R8 user release");
    check(isWarm && !isCold, "R1 warm flag", {isCold, isWarm}, 2'b01);
    check(restartAddr == 16'h5634, "R1 warm restart", restartAddr, 16'h5634);
  endtask

  task automatic testGlitch();
    @(negedge clk);
    porRaw = 1'b1;
    cyc(DEB - 1);
    porRaw = 1'b0;
    cyc(10);
    check(isWarm && restartAddr == 16'h5634, "R5 glitch ignored", restartAddr, 16'h5634);
    check(ram[BASE[7:0] + 8'd2] == (8'h34 ^ KEY), "R5 glitch no clear",
          ram[BASE[7:0] + 8'd2], 8'h34 ^ KEY);
    porRaw = 1'b1;
    cyc(DEB + 4);
    check(!isWarm && ram[BASE[7:0] + 8'd2] == 8'h00, "R5 long pulse accepted",
          ram[BASE[7:0] + 8'd2], 0);
    porRaw = 1'b0;
    waitDone("R8 second power-on");
    check(isCold && restartAddr == WARM, "R2 cold after power cycle", restartAddr, WARM);
  endtask

  task automatic testCorrupt();
    setRecord(8'h23, 8'h77, 8'h00);
    userReset();
    waitDone("R2 corrupt release");
    check(isCold && !isWarm, "R2 bad check gives cold", {isCold, isWarm}, 2'b10);
    @(negedge clk);
    checkRecord("R2 rewrite", WARM[7:0], WARM[15:8]);
  endtask

  task automatic testAbort();
    int n = 0;
    setRecord(8'h55, 8'h66, 8'h77);
    userReset();
    while (!(memWe && memAddr == BASE + 16'd1) && n < 60) begin
      @(negedge clk);
      n++;
    end
    userRstN = 1'b0;
    cyc(2);
    check(ram[BASE[7:0]] == WARM[7:0], "R2 low byte first", ram[BASE[7:0]], WARM[7:0]);
    check(ram[BASE[7:0] + 8'd2] == 8'h77, "R7 check byte untouched",
          ram[BASE[7:0] + 8'd2], 8'h77);
    check(!isCold && !isWarm && !done, "R7 no flag on abort", {done, isCold, isWarm}, 0);
    userRstN = 1'b1;
    waitDone("R7 restart after abort");
    check(isCold, "R7 cold after restart", int'(isCold), 1);
    @(negedge clk);
    checkRecord("R7 record complete", WARM[7:0], WARM[15:8]);
  endtask

  initial begin
    porRaw = 1'b1; userRstN = 1'b0; pokeEn = 1'b0; pokeAddr = '0; pokeData = '0;
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    cyc(2);
    userRstN = 1'b1;
    testPowerOn();
    testUserWarm();
    testGlitch();
    testUserWarm();
    testCorrupt();
    testAbort();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule